// File: doc/BRIEF.md
# Byte-Commanded Logic Sample Capture Engine

This block samples eight digital probe inputs at a programmable rate derived from the system clock and streams each sample as one byte to a host-side byte stream. It has no trigger logic and does no analysis. Every probe is captured on every sample, and the raw bit pattern is forwarded unchanged.

Commands arrive on a valid/ready byte input. A rate command is two bytes: the opcode 0x01, then a divider byte. The sample interval is (1 + divider) clock cycles, so with a 48 MHz clock a divider of 23 gives 2 MHz, 1 gives 24 MHz and 239 gives 200 kHz. A read request carries a sample count. The engine then produces exactly that many bytes on a valid/ready output stream, with a ceiling of 4096 per request. If the output is stalled when a sample is due, that sample is skipped and a sticky overrun flag is raised.

Top module: `probe_capture_engine`

## Requirements
- R1: After reset, out_valid_o and overrun_o are 0, req_ready_o and cmd_ready_o are 1, and the divider is 23.
- R2: An accepted byte 0x01 in the opcode position, followed by an accepted byte D, sets the divider to D.
- R3: While a transfer runs with the output ready, consecutive output bytes are exactly divider+1 clock cycles apart.
- R4: A byte other than 0x01 in the opcode position is discarded, and the byte after it is treated as a new opcode.
- R5: A divider byte of 0 is stored and used as divider 1.
- R6: Bit 7-k of each output byte is probe_i[k] (probe_i[0], probe 1, lands in the MSB; probe_i[7] lands in bit 0), with no channel masking.
- R7: An accepted request for N samples yields exactly N output bytes, and a request for 0 yields none.
- R8: A request for more than 4096 samples yields exactly 4096 bytes.
- R9: A sample due while out_valid_o is high and out_ready_i is low is skipped and not counted, and it sets overrun_o. The flag stays set until the next accepted request clears it.
- R10: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o does not change.
- R11: req_ready_o is 0 while a transfer has samples or a byte outstanding, and a request offered then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (48 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| probe_i | input | 8 | Asynchronous probe inputs, index 0 is probe 1 |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_data_i | input | 8 | Command byte |
| cmd_ready_o | output | 1 | Command byte accepted (always 1) |
| req_valid_i | input | 1 | Read request valid |
| req_count_i | input | REQ_W | Requested sample count |
| req_ready_o | output | 1 | Engine idle, request can be accepted |
| out_valid_o | output | 1 | Sample byte valid |
| out_data_o | output | 8 | Sample byte |
| out_ready_i | input | 1 | Downstream accepts the byte |
| overrun_o | output | 1 | Sticky flag: a sample was skipped because of a stall |

## Verification
A walking one on the probes separates a correct bit reversal from an identity or shifted mapping. Random probe patterns, dividers and counts cross-check the spacing and the count against values the bench computes itself. Command sequences that use bad opcodes, a zero divider or a misaligned resynchronisation show up as a wrong byte spacing. Stalled-output, oversized, zero-length and busy-time requests exercise the overrun skip, the 4096 ceiling and the request gating.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int PROBE_W = 8;
    localparam int BYTE_W  = 8;
    localparam logic [BYTE_W-1:0] OPC_SET_RATE = 8'h01;

    typedef logic [PROBE_W-1:0] sample_t;

    typedef enum logic {
        PS_OPCODE  = 1'b0,
        PS_DIVIDER = 1'b1
    } parse_state_e;

    typedef struct packed {
        logic    valid;
        sample_t data;
    } out_beat_t;

    // probe index k goes to byte bit (PROBE_W-1-k)
    function automatic sample_t pack_probes(input sample_t p);
        sample_t r;
        for (int i = 0; i < PROBE_W; i++) r[PROBE_W-1-i] = p[i];
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] legal_div(input logic [BYTE_W-1:0] d);
        return (d == '0) ? BYTE_W'(1) : d;
    endfunction
endpackage

// File: rtl/cap_cmd_parser.sv
module cap_cmd_parser
    import cap_pkg::*;
#(
    parameter int DEF_DIV = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic [BYTE_W-1:0] div_o
);
    parse_state_e      state_q;
    logic [BYTE_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_OPCODE;
            div_q   <= legal_div(BYTE_W'(DEF_DIV));
        end else if (cmd_valid) begin
            case (state_q)
                PS_OPCODE: begin
                    if (cmd_data == OPC_SET_RATE) state_q <= PS_DIVIDER;
                end
                default: begin
                    div_q   <= legal_div(cmd_data);
                    state_q <= PS_OPCODE;
                end
            endcase
        end
    end

    assign div_o = div_q;

    // R5: a zero divider never reaches the rate generator
    p_div_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        div_q != '0);

    // R4: a non-opcode byte seen in opcode position leaves the parser waiting for an opcode
    p_resync_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && state_q == PS_OPCODE && cmd_data != OPC_SET_RATE)
        |=> (state_q == PS_OPCODE && $stable(div_q)));
endmodule

// File: rtl/cap_rate_gen.sv
module cap_rate_gen
    import cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BYTE_W-1:0] div,
    output logic              strobe
);
    logic [BYTE_W-1:0] cnt_q;

    assign strobe = en && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!en || cnt_q == '0) begin
            cnt_q <= div;
        end else begin
            cnt_q <= cnt_q - BYTE_W'(1);
        end
    end

    // R3: with a divider of at least 1, strobes are never back to back
    p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

// File: rtl/cap_probe_sync.sv
module cap_probe_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= din;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/probe_capture_engine.sv
module probe_capture_engine
    import cap_pkg::*;
#(
    parameter int MAX_XFER    = 4096,
    parameter int REQ_W       = 16,
    parameter int DEF_DIV     = 23,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PROBE_W-1:0]   probe_i,
    input  logic                 cmd_valid_i,
    input  logic [BYTE_W-1:0]    cmd_data_i,
    output logic                 cmd_ready_o,
    input  logic                 req_valid_i,
    input  logic [REQ_W-1:0]     req_count_i,
    output logic                 req_ready_o,
    output logic                 out_valid_o,
    output logic [PROBE_W-1:0]   out_data_o,
    input  logic                 out_ready_i,
    output logic                 overrun_o
);
    localparam int CNT_W = $clog2(MAX_XFER + 1);
    localparam logic [REQ_W-1:0] MAX_REQ = REQ_W'(MAX_XFER);

    logic [BYTE_W-1:0] div_w;
    logic              strobe_w;
    sample_t           sync_w;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  clamp_w;
    out_beat_t         out_q;
    logic              ovr_q;
    logic              busy_w;
    logic              req_fire_w;
    logic              stall_w;

    cap_cmd_parser #(.DEF_DIV(DEF_DIV)) u_parser (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid_i), .cmd_data(cmd_data_i), .div_o(div_w)
    );

    cap_rate_gen u_rate (
        .clk(clk), .rst(rst), .en(remain_q != '0), .div(div_w), .strobe(strobe_w)
    );

    cap_probe_sync #(.W(PROBE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(probe_i), .dout(sync_w)
    );

    assign cmd_ready_o = 1'b1;
    assign busy_w      = (remain_q != '0) || out_q.valid;
    assign req_ready_o = !busy_w;
    assign req_fire_w  = req_valid_i && !busy_w;
    assign stall_w     = out_q.valid && !out_ready_i;
    assign clamp_w     = (req_count_i > MAX_REQ) ? CNT_W'(MAX_XFER) : req_count_i[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            out_q    <= '0;
            ovr_q    <= 1'b0;
        end else begin
            if (out_q.valid && out_ready_i) out_q.valid <= 1'b0;
            if (req_fire_w) begin
                remain_q <= clamp_w;
                ovr_q    <= 1'b0;
            end else if (strobe_w) begin
                if (stall_w) begin
                    ovr_q <= 1'b1;
                end else begin
                    out_q.valid <= 1'b1;
                    out_q.data  <= pack_probes(sync_w);
                    remain_q    <= remain_q - CNT_W'(1);
                end
            end
        end
    end

    assign out_valid_o = out_q.valid;
    assign out_data_o  = out_q.data;
    assign overrun_o   = ovr_q;

    // R10: a stalled byte is held unchanged
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R9: overrun is sticky until a request is accepted
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !(req_valid_i && req_ready_o)) |=> overrun_o);

    // R9: an accepted request clears overrun
    p_overrun_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !overrun_o);

    // R8: the outstanding count never exceeds the ceiling
    p_remain_cap_r8: assert property (@(posedge clk) disable iff (rst)
        remain_q <= CNT_W'(MAX_XFER));

    // R11: while busy, a request cannot raise the outstanding count
    p_busy_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (!req_ready_o) |=> (remain_q <= $past(remain_q)));
endmodule

// File: tb/probe_capture_engine_tb.sv
module probe_capture_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  probe_i = '0;
    logic        cmd_valid_i = 1'b0;
    logic [7:0]  cmd_data_i = '0;
    logic        cmd_ready_o;
    logic        req_valid_i = 1'b0;
    logic [15:0] req_count_i = '0;
    logic        req_ready_o;
    logic        out_valid_o;
    logic [7:0]  out_data_o;
    logic        out_ready_i = 1'b1;
    logic        overrun_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_got, data_err, gap_err, exp_gap, last_cyc;
    logic [7:0] exp_byte;
    logic       done_flag = 1'b0;

    always #10 clk = ~clk;   // 50 MHz bench clock

    probe_capture_engine dut_i (
        .clk(clk), .rst(rst), .probe_i(probe_i),
        .cmd_valid_i(cmd_valid_i), .cmd_data_i(cmd_data_i), .cmd_ready_o(cmd_ready_o),
        .req_valid_i(req_valid_i), .req_count_i(req_count_i), .req_ready_o(req_ready_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
        .overrun_o(overrun_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid_o && out_ready_i) begin
            if (out_data_o !== exp_byte) data_err++;
            if (n_got > 0 && exp_gap != 0 && (cyc - last_cyc) != exp_gap) gap_err++;
            last_cyc = cyc;
            n_got++;
        end
    end

    function automatic logic [7:0] rev8(input logic [7:0] p);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = p[i];
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_data_i  = b;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic start_xfer(input int cnt, input int gap, input logic [7:0] p);
        probe_i = p;
        exp_byte = rev8(p);
        repeat (4) @(negedge clk);
        n_got = 0; data_err = 0; gap_err = 0; exp_gap = gap;
        req_count_i = 16'(cnt);
        req_valid_i = 1'b1;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic finish_xfer();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (req_ready_o && k > 2) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic xfer(input int cnt, input int exp_n, input int gap, input logic [7:0] p, input string tag);
        start_xfer(cnt, gap, p);
        finish_xfer();
        chk(n_got == exp_n, {tag, " count"}, n_got, exp_n);
        chk(data_err == 0, "R6 byte packing", data_err, 0);
        if (gap != 0) chk(gap_err == 0, "R3 sample spacing", gap_err, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid_o == 1'b0, "R1 out_valid", out_valid_o, 0);
        chk(overrun_o == 1'b0, "R1 overrun", overrun_o, 0);
        chk(req_ready_o == 1'b1, "R1 req_ready", req_ready_o, 1);
        chk(cmd_ready_o == 1'b1, "R1 cmd_ready", cmd_ready_o, 1);
        xfer(3, 3, 24, 8'hA5, "R1 default divider 23");

        // R6 walking one on the probes
        for (int k = 0; k < 8; k++) xfer(2, 2, 24, 8'(1 << k), "R6 walking one");

        // R2 / R3 directed dividers
        send_cmd(8'h01); send_cmd(8'd1);
        xfer(20, 20, 2, 8'h3C, "R3 divider 1");
        send_cmd(8'h01); send_cmd(8'd239);
        xfer(3, 3, 240, 8'hC3, "R3 divider 239");

        // R4 bad opcodes: 0x05 and 0x07 both dropped, divider stays 239
        send_cmd(8'h05); send_cmd(8'h07);
        xfer(2, 2, 240, 8'h11, "R4 bad opcode ignored");
        send_cmd(8'h02); send_cmd(8'h01); send_cmd(8'd4);
        xfer(6, 6, 5, 8'h80, "R4 resync then R2 divider 4");

        // R5 zero divider acts as 1
        send_cmd(8'h01); send_cmd(8'h00);
        xfer(10, 10, 2, 8'h5A, "R5 zero divider");

        // R7 zero-length request, R8 clamp
        xfer(0, 0, 2, 8'hFF, "R7 zero request");
        xfer(5000, 4096, 2, 8'h96, "R8 clamp");

        // R2/R3/R7 random
        for (int it = 0; it < 8; it++) begin
            int d, n;
            logic [7:0] p;
            d = 1 + int'($urandom_range(29));
            n = 1 + int'($urandom_range(39));
            p = 8'($urandom);
            send_cmd(8'h01); send_cmd(8'(d));
            xfer(n, n, d + 1, p, "R7 random request");
        end

        // R11 requests while busy are ignored
        send_cmd(8'h01); send_cmd(8'd5);
        start_xfer(10, 6, 8'h42);
        begin
            int rdy_seen;
            rdy_seen = 0;
            req_count_i = 16'd7;
            req_valid_i = 1'b1;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (req_ready_o) rdy_seen++;
            end
            req_valid_i = 1'b0;
            chk(rdy_seen == 0, "R11 req_ready while busy", rdy_seen, 0);
        end
        finish_xfer();
        chk(n_got == 10, "R11 busy request ignored", n_got, 10);

        // R9 / R10 overrun under stall
        send_cmd(8'h01); send_cmd(8'd3);
        out_ready_i = 1'b0;
        start_xfer(3, 0, 8'h0F);
        repeat (20) @(negedge clk);
        chk(overrun_o == 1'b1, "R9 overrun set", overrun_o, 1);
        chk(out_valid_o == 1'b1, "R10 valid held", out_valid_o, 1);
        chk(out_data_o == rev8(8'h0F), "R10 data held", out_data_o, rev8(8'h0F));
        repeat (15) @(negedge clk);
        chk(out_data_o == rev8(8'h0F), "R10 data still held", out_data_o, rev8(8'h0F));
        out_ready_i = 1'b1;
        finish_xfer();
        chk(n_got == 3, "R9 skipped samples not counted", n_got, 3);
        chk(data_err == 0, "R6 byte packing after stall", data_err, 0);
        chk(overrun_o == 1'b1, "R9 overrun sticky", overrun_o, 1);
        start_xfer(1, 0, 8'h0F);
        chk(overrun_o == 1'b0, "R9 overrun cleared", overrun_o, 0);
        finish_xfer();
        chk(n_got == 1, "R7 single sample", n_got, 1);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 190000; k++) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule